// File: doc/BRIEF.md
# Hart Mailbox Memory for Run-Control Debug

This block is the small memory-mapped slave that a halted hart talks to from its debug park loop. The hart uses ordinary word loads and stores. It announces its state by storing to four fixed control offsets. It polls a per-hart flag byte to learn whether to run a command or return to normal execution. It then fetches a "whereto" word that the block builds at run time as a jump to the right routine. The block also passes each hart's halt request straight through as its debug request line.

The control bank feeds three kinds of pulses per hart:
- halt requests, as levels;
- resume requests, which set that hart's RESUME flag;
- go requests, which set that hart's GO flag and latch which target the next whereto jump must reach.

The block reports the following back to the control bank:
- a halted bit per hart;
- a one-cycle resuming pulse per hart;
- a one-cycle exception pulse.

A window decoder sits in front of the slave. It claims every address whose bits above bit 11 are all zero and forwards every other request to a data-memory port. The one response channel returns whichever side served the request.

The request side is a valid/ready stream. The slave never applies back-pressure, so `req_ready` is held high and a request is taken on every cycle that `req_valid` is high. Each accepted request, read or write, produces exactly one `rsp_valid` beat on the following cycle. The hart must accept that beat, because the response channel has no ready.

Top module: `mbx_hart_mailbox`

## Requirements
- R1: `debug_req[i]` follows `haltreq[i]` combinationally for every hart.
- R2: An in-window write to offset 0x100 sets `halted[h]`, where the write data equals the hart number h. Data naming no existing hart changes nothing. The bit is visible the cycle after the write.
- R3: A `resume_req[i]` pulse sets bit 1 (RESUME) of hart i's flag byte. Flag byte h sits at offset 0x400+h: word 0x400+4*(h/4), byte lane h%4 (bits 8*(h%4)+7 to 8*(h%4)).
- R4: A `go_req[i]` pulse sets bit 0 (GO) of hart i's flag byte. An in-window write to offset 0x108 clears the GO bit of every hart.
- R5: An in-window write to offset 0x110, with data equal to hart number h, clears `halted[h]` and hart h's RESUME bit. It also raises `resuming[h]` for exactly one cycle.
- R6: An in-window write to offset 0x118 raises `exception` for exactly one cycle.
- R7: A read of offset 0x300 returns a JAL with rd=x0. The instruction bits are {imm[20], imm[10:1], imm[11], imm[19:12], 5'b0, 7'b1101111}. The jump targets offset 0x360 if `cmd_progbuf` was high at the most recent go pulse, and offset 0x338 otherwise. The abstract-command target 0x338 is selected after reset.
- R8: A request is in the window when address bits 31:12 are zero. Any other request drives `dmem_valid` in the same cycle, and its response data is `dmem_rdata`.
- R9: `req_ready` is always high. Every accepted request yields one `rsp_valid` beat on the next cycle. In-window writes, and reads of unmapped in-window offsets, return zero.
- R10: When a resume pulse and a RESUMING store for the same hart land in the same cycle, the RESUME bit ends up set.
- R11: Hart stores into the flag words leave all flag bytes unchanged.
- R12: After reset all halted bits, flag bytes and pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| haltreq | input | N_HARTS | Halt request per hart from the control bank |
| resume_req | input | N_HARTS | Pulse: set the RESUME flag for the hart |
| go_req | input | N_HARTS | Pulse: set the GO flag for the hart |
| cmd_progbuf | input | 1 | Target chosen with a go pulse: 1 program buffer, 0 abstract routine |
| req_valid | input | 1 | Hart bus request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_we | input | 1 | 1 store, 0 load |
| req_addr | input | ADDR_W | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response beat, one cycle after each request |
| rsp_rdata | output | 32 | Load data |
| dmem_valid | output | 1 | Request forwarded to data memory |
| dmem_we | output | 1 | Forwarded write enable |
| dmem_addr | output | ADDR_W | Forwarded address |
| dmem_wdata | output | 32 | Forwarded write data |
| dmem_rdata | input | 32 | Data-memory read data, valid the cycle after the request |
| debug_req | output | N_HARTS | Debug request to each hart |
| halted | output | N_HARTS | Halted mark per hart |
| resuming | output | N_HARTS | One-cycle pulse when a hart reports leaving debug |
| exception | output | 1 | One-cycle pulse on a debug-code fault report |

## Verification
The bench uses six harts. Flags for harts 4 and 5 therefore live in a second word, and a design with the wrong lane or word indexing would return bytes in the wrong place. It sends HALTED and RESUMING stores that name a hart number past the last hart; a decoder that truncates the data would mark a real hart instead. It lands a resume pulse on the same cycle as that hart's RESUMING store, where clear-over-set priority would drop the fresh request. It checks that the whereto word flips between the two jump encodings as the go target changes, and that a store to 0x80000100 reaches data memory rather than marking a hart halted; a decoder that looked only at the low 12 bits would wrongly set that halted bit.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [11:0] OFF_HALTED    = 12'h100;
  localparam logic [11:0] OFF_GOING     = 12'h108;
  localparam logic [11:0] OFF_RESUMING  = 12'h110;
  localparam logic [11:0] OFF_EXCEPTION = 12'h118;
  localparam logic [11:0] OFF_WHERETO   = 12'h300;
  localparam logic [11:0] OFF_ABSCMD    = 12'h338;
  localparam logic [11:0] OFF_PROGBUF   = 12'h360;
  localparam logic [11:0] OFF_FLAGS     = 12'h400;
  localparam int          WIN_BITS      = 12;
  localparam int          FLAG_GO       = 0;
  localparam int          FLAG_RESUME   = 1;

  typedef enum logic [2:0] {
    OP_NONE, OP_HALTED, OP_GOING, OP_RESUMING, OP_EXCEPTION
  } mbx_op_e;

  // JAL x0 with a signed byte displacement given as bits 20:1
  function automatic logic [31:0] jal_x0(input logic [20:1] d);
    return {d[20], d[10:1], d[11], d[19:12], 5'd0, 7'b1101111};
  endfunction

  localparam logic [11:0] D_ABS  = OFF_ABSCMD - OFF_WHERETO;
  localparam logic [11:0] D_PBUF = OFF_PROGBUF - OFF_WHERETO;
  localparam logic [31:0] JAL_ABS  = jal_x0({{9{D_ABS[11]}}, D_ABS[11:1]});
  localparam logic [31:0] JAL_PBUF = jal_x0({{9{D_PBUF[11]}}, D_PBUF[11:1]});
endpackage

// File: rtl/mbx_window_dec.sv
module mbx_window_dec #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 12
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              in_win,
  output logic              dmem_valid
);
  assign in_win     = (req_addr[ADDR_W-1:WIN_BITS] == '0);
  assign dmem_valid = req_valid & ~in_win;
endmodule

// File: rtl/mbx_store_dec.sv
module mbx_store_dec
  import mbx_pkg::*;
#(
  parameter int N_HARTS = 4
) (
  input  logic               wr_en,
  input  logic [11:0]        off,
  input  logic [31:0]        wdata,
  output mbx_op_e            op,
  output logic [N_HARTS-1:0] hart_sel
);
  always_comb begin
    op = OP_NONE;
    if (wr_en) begin
      unique case (off)
        OFF_HALTED:    op = OP_HALTED;
        OFF_GOING:     op = OP_GOING;
        OFF_RESUMING:  op = OP_RESUMING;
        OFF_EXCEPTION: op = OP_EXCEPTION;
        default:       op = OP_NONE;
      endcase
    end
  end

  // store data carries a hart number; out-of-range numbers select nobody
  for (genvar h = 0; h < N_HARTS; h++) begin : g_sel
    assign hart_sel[h] = (wdata == 32'(h));
  end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
  parameter int N_HARTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_HARTS-1:0] go_set,
  input  logic               go_clr_all,
  input  logic [N_HARTS-1:0] resume_set,
  input  logic [N_HARTS-1:0] resume_clr,
  output logic [N_HARTS-1:0] go_bits,
  output logic [N_HARTS-1:0] resume_bits
);
  for (genvar h = 0; h < N_HARTS; h++) begin : g_hart
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        go_bits[h]     <= 1'b0;
        resume_bits[h] <= 1'b0;
      end else begin
        // a fresh set wins over a clear landing in the same cycle
        go_bits[h]     <= go_set[h] | (go_bits[h] & ~go_clr_all);
        resume_bits[h] <= resume_set[h] | (resume_bits[h] & ~resume_clr[h]);
      end
    end
  end
endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
#(
  parameter int N_HARTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mbx_op_e            op,
  input  logic [N_HARTS-1:0] hart_sel,
  output logic [N_HARTS-1:0] halted,
  output logic [N_HARTS-1:0] resuming,
  output logic               exception
);
  logic [N_HARTS-1:0] set_h, clr_h;

  assign set_h = (op == OP_HALTED)   ? hart_sel : '0;
  assign clr_h = (op == OP_RESUMING) ? hart_sel : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted    <= '0;
      resuming  <= '0;
      exception <= 1'b0;
    end else begin
      halted    <= (halted & ~clr_h) | set_h;
      resuming  <= clr_h;
      exception <= (op == OP_EXCEPTION);
    end
  end
endmodule

// File: rtl/mbx_hart_mailbox.sv
module mbx_hart_mailbox
  import mbx_pkg::*;
#(
  parameter int N_HARTS = 4,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_HARTS-1:0] haltreq,
  input  logic [N_HARTS-1:0] resume_req,
  input  logic [N_HARTS-1:0] go_req,
  input  logic               cmd_progbuf,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               dmem_valid,
  output logic               dmem_we,
  output logic [ADDR_W-1:0]  dmem_addr,
  output logic [31:0]        dmem_wdata,
  input  logic [31:0]        dmem_rdata,
  output logic [N_HARTS-1:0] debug_req,
  output logic [N_HARTS-1:0] halted,
  output logic [N_HARTS-1:0] resuming,
  output logic               exception
);
  localparam int N_FLAG_WORDS = (N_HARTS + 3) / 4;

  logic               in_win;
  logic [11:0]        off;
  mbx_op_e            op;
  logic [N_HARTS-1:0] hart_sel;
  logic [N_HARTS-1:0] go_bits, resume_bits;
  logic               progbuf_q;
  logic [31:0]        rd_d, rd_q;
  logic               sel_q;

  assign req_ready  = 1'b1;
  assign debug_req  = haltreq;
  assign off        = req_addr[11:0];
  assign dmem_we    = req_we;
  assign dmem_addr  = req_addr;
  assign dmem_wdata = req_wdata;

  mbx_window_dec #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_win (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .in_win    (in_win),
    .dmem_valid(dmem_valid)
  );

  mbx_store_dec #(.N_HARTS(N_HARTS)) u_sdec (
    .wr_en   (req_valid & req_we & in_win),
    .off     (off),
    .wdata   (req_wdata),
    .op      (op),
    .hart_sel(hart_sel)
  );

  mbx_flags #(.N_HARTS(N_HARTS)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_set     (go_req),
    .go_clr_all (op == OP_GOING),
    .resume_set (resume_req),
    .resume_clr ((op == OP_RESUMING) ? hart_sel : '0),
    .go_bits    (go_bits),
    .resume_bits(resume_bits)
  );

  mbx_status #(.N_HARTS(N_HARTS)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .hart_sel (hart_sel),
    .halted   (halted),
    .resuming (resuming),
    .exception(exception)
  );

  // jump target latched with each go pulse
  always_ff @(posedge clk) begin
    if (!rst_n)       progbuf_q <= 1'b0;
    else if (|go_req) progbuf_q <= cmd_progbuf;
  end

  // read mux for in-window loads
  always_comb begin
    rd_d = '0;
    if (off == OFF_WHERETO) begin
      rd_d = progbuf_q ? JAL_PBUF : JAL_ABS;
    end else begin
      for (int w = 0; w < N_FLAG_WORDS; w++) begin
        if (off == 12'(OFF_FLAGS + 12'(4 * w))) begin
          for (int l = 0; l < 4; l++) begin
            if (4 * w + l < N_HARTS) begin
              rd_d[8*l +: 8] = {6'd0, resume_bits[4*w+l], go_bits[4*w+l]};
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      sel_q     <= 1'b0;
      rd_q      <= '0;
    end else begin
      rsp_valid <= req_valid;
      sel_q     <= in_win;
      rd_q      <= (req_valid && !req_we && in_win) ? rd_d : '0;
    end
  end

  assign rsp_rdata = sel_q ? rd_q : dmem_rdata;
endmodule

// File: rtl/mbx_hart_mailbox_chk.sv
module mbx_hart_mailbox_chk #(
  parameter int N_HARTS = 4,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_we,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [N_HARTS-1:0] go_req,
  input logic [N_HARTS-1:0] go_bits,
  input logic               rsp_valid,
  input logic [N_HARTS-1:0] halted,
  input logic [N_HARTS-1:0] resuming,
  input logic               exception,
  input logic               dmem_valid
);
  logic wr_halted, wr_going, wr_resuming, wr_exc;
  assign wr_halted   = req_valid && req_we && req_addr == ADDR_W'(32'h100);
  assign wr_going    = req_valid && req_we && req_addr == ADDR_W'(32'h108);
  assign wr_resuming = req_valid && req_we && req_addr == ADDR_W'(32'h110);
  assign wr_exc      = req_valid && req_we && req_addr == ADDR_W'(32'h118);

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_halt_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((halted & ~$past(halted)) != '0) |-> $past(wr_halted));
  assert_going_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_going && go_req == '0) |=> (go_bits == '0));
  assert_resuming_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(resuming));
  assert_resuming_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resuming != '0) |-> $past(wr_resuming));
  assert_exc_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exception |-> $past(wr_exc));
  assert_dmem_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_valid |-> (req_valid && req_addr[ADDR_W-1:12] != '0));
endmodule

bind mbx_hart_mailbox mbx_hart_mailbox_chk #(.N_HARTS(N_HARTS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_we    (req_we),
  .req_addr  (req_addr),
  .go_req    (go_req),
  .go_bits   (go_bits),
  .rsp_valid (rsp_valid),
  .halted    (halted),
  .resuming  (resuming),
  .exception (exception),
  .dmem_valid(dmem_valid)
);

// File: tb/sim_mbx_hart_mailbox.sv
module sim_mbx_hart_mailbox;
  localparam int NH = 6;
  localparam logic [31:0] DMEM_VAL = 32'hCAFE_F00D;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NH-1:0] haltreq = '0, resume_req = '0, go_req = '0;
  logic          cmd_progbuf = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [31:0]   req_addr = '0, req_wdata = '0;
  logic [31:0]   dmem_rdata = DMEM_VAL;
  logic          req_ready, rsp_valid, dmem_valid, dmem_we, exception;
  logic [31:0]   rsp_rdata, dmem_addr, dmem_wdata;
  logic [NH-1:0] debug_req, halted, resuming;

  mbx_hart_mailbox #(.N_HARTS(NH), .ADDR_W(32)) u0 (.*);

  int tests = 0, fails = 0;
  logic [31:0] expq[$];
  string tagq[$];
  logic dv_seen;
  logic [31:0] mon_e;
  string mon_t;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] jal0(input int d);
    logic [20:0] i;
    i = d[20:0];
    return {i[20], i[10:1], i[11], i[19:12], 5'd0, 7'b1101111};
  endfunction

  // driver: one request per cycle, expected response queued for the monitor
  task automatic bus(input logic we, input logic [31:0] a, input logic [31:0] d,
                     input logic [31:0] exp, input string tag);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    expq.push_back(exp); tagq.push_back(tag);
    #1 dv_seen = dmem_valid;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic pulse_go(input logic [NH-1:0] m, input logic pb);
    go_req = m; cmd_progbuf = pb;
    @(negedge clk);
    go_req = '0;
  endtask

  task automatic pulse_resume(input logic [NH-1:0] m);
    resume_req = m;
    @(negedge clk);
    resume_req = '0;
  endtask

  // monitor: pop and compare each response beat
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) chk(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
      else begin
        mon_e = expq.pop_front();
        mon_t = tagq.pop_front();
        chk(rsp_rdata == mon_e, mon_t, rsp_rdata, mon_e);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(halted == '0, "R12 halted reset", 32'(halted), 0);
    chk(resuming == '0 && exception == 1'b0, "R12 pulses reset", {resuming, exception}, 0);
    chk(req_ready == 1'b1, "R9 ready", 32'(req_ready), 1);
    bus(0, 32'h400, 0, 32'h0, "R12 flags word0 reset");
    bus(0, 32'h404, 0, 32'h0, "R12 flags word1 reset");
    bus(0, 32'h300, 0, jal0(32'h38), "R7 whereto reset abstract");

    // R1
    haltreq = 6'b101001;
    #1 chk(debug_req == 6'b101001, "R1 debug_req", 32'(debug_req), 32'h29);
    haltreq = 6'b010110;
    #1 chk(debug_req == 6'b010110, "R1 debug_req", 32'(debug_req), 32'h16);
    @(negedge clk);

    // R2
    bus(1, 32'h100, 2, 0, "R2 write rsp");
    chk(halted == 6'b000100, "R2 halt hart2", 32'(halted), 32'h04);
    bus(1, 32'h100, 5, 0, "R2 write rsp");
    chk(halted == 6'b100100, "R2 halt hart5", 32'(halted), 32'h24);
    bus(1, 32'h100, 9, 0, "R2 write rsp");
    chk(halted == 6'b100100, "R2 out-of-range id ignored", 32'(halted), 32'h24);

    // R3
    pulse_resume(6'b100000);
    bus(0, 32'h404, 0, 32'h0000_0200, "R3 hart5 RESUME lane1 word1");
    bus(0, 32'h400, 0, 32'h0, "R3 word0 untouched");

    // R4 / R7
    pulse_go(6'b000101, 1'b1);
    bus(0, 32'h400, 0, 32'h0001_0001, "R4 GO harts 0 and 2");
    bus(0, 32'h300, 0, jal0(32'h60), "R7 whereto progbuf");
    bus(1, 32'h108, 0, 0, "R4 write rsp");
    bus(0, 32'h400, 0, 32'h0, "R4 GOING clears GO");
    bus(0, 32'h404, 0, 32'h0000_0200, "R4 GOING keeps RESUME");

    // R11
    bus(1, 32'h400, 32'hFFFF_FFFF, 0, "R11 write rsp");
    bus(1, 32'h404, 32'hFFFF_FFFF, 0, "R11 write rsp");
    bus(0, 32'h400, 0, 32'h0, "R11 flag store ignored word0");
    bus(0, 32'h404, 0, 32'h0000_0200, "R11 flag store ignored word1");

    // R5
    bus(1, 32'h110, 5, 0, "R5 write rsp");
    chk(resuming == 6'b100000, "R5 resuming pulse", 32'(resuming), 32'h20);
    chk(halted == 6'b000100, "R5 halted cleared", 32'(halted), 32'h04);
    @(negedge clk);
    chk(resuming == '0, "R5 pulse one cycle", 32'(resuming), 0);
    bus(0, 32'h404, 0, 32'h0, "R5 RESUME cleared");
    bus(1, 32'h110, 7, 0, "R5 write rsp");
    chk(resuming == '0 && halted == 6'b000100, "R5 out-of-range id ignored", 32'(halted), 32'h04);

    // R10
    resume_req = 6'b000100;
    bus(1, 32'h110, 2, 0, "R10 write rsp");
    resume_req = '0;
    chk(halted == '0, "R10 halted cleared", 32'(halted), 0);
    bus(0, 32'h400, 0, 32'h0002_0000, "R10 set beats clear");

    // R6
    bus(1, 32'h118, 0, 0, "R6 write rsp");
    chk(exception == 1'b1, "R6 exception pulse", 32'(exception), 1);
    @(negedge clk);
    chk(exception == 1'b0, "R6 pulse one cycle", 32'(exception), 0);

    // R7 back to abstract routine
    pulse_go(6'b000010, 1'b0);
    bus(0, 32'h300, 0, jal0(32'h38), "R7 whereto abstract");
    bus(0, 32'h400, 0, 32'h0002_0100, "R4 GO hart1 with RESUME hart2");

    // R8
    bus(0, 32'h0000_1000, 0, DMEM_VAL, "R8 read from dmem");
    chk(dv_seen == 1'b1, "R8 dmem_valid out of window", 32'(dv_seen), 1);
    bus(1, 32'h8000_0100, 0, DMEM_VAL, "R8 write rsp from dmem");
    chk(dv_seen == 1'b1, "R8 dmem_valid high addr", 32'(dv_seen), 1);
    chk(halted == '0, "R8 out-of-window HALTED ignored", 32'(halted), 0);
    bus(0, 32'h0000_0300, 0, jal0(32'h38), "R8 in-window read");
    chk(dv_seen == 1'b0, "R8 dmem_valid low in window", 32'(dv_seen), 0);

    // R9
    bus(0, 32'h204, 0, 32'h0, "R9 unmapped read zero");
    bus(1, 32'h300, 32'h1234_5678, 0, "R9 in-window write zero");
    @(negedge clk);
    chk(expq.size() == 0, "R9 all responses seen", 32'(expq.size()), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule